// File: doc/BRIEF.md
# CRT Horizontal Blank and Sync Generator

This block produces the horizontal blanking and horizontal sync strobes of a character-clocked CRT display controller. An 8-bit character counter steps once on every character-clock enable and returns to zero after reaching a programmed line total. Blanking and sync are both windows over that counter. Each opens when the counter reaches its programmed start position and closes when the low bits of the counter reach its programmed end value.

The end values are deliberately narrow. The sync end is a 6-bit value. The blanking end is 6 bits in standard mode and 8 bits in extended mode. Software therefore programs each end as start plus length, truncated to that width. The end value is assembled from a 5-bit low field, a single bit-5 field and, for extended blanking only, a 2-bit high field. The sync strobe can also be pushed back by 0 to 3 character clocks to cover pixel-pipeline latency. This delay moves the rising and the falling edge alike.

All outputs update only on character-clock enables, and a field change is used at the next enable. Both strobes are active-high. Any polarity inversion and all vertical timing belong to other blocks.

Top module: `crt_hblank_hsync`

## Requirements
- R1: While `rst_n` is low, `hcount` is 0 and `blank` and `sync` are 0.
- R2: On each cycle with `char_en` high, `hcount` goes up by one, except that it becomes 0 when it equals `h_total`.
- R3: `blank` rises in the same cycle that `hcount` becomes `blank_start`, so it is high while `hcount` shows the start value.
- R4: In standard mode (`ext_mode` = 0) the blank end value is the 6-bit value {`blank_end_b5`, `blank_end_lo[4:0]`}. `blank` falls when the low 6 bits of `hcount` become that value, so the pulse lasts (end − start) mod 64 characters, and a difference of 0 means 64.
- R5: In extended mode (`ext_mode` = 1) the blank end value is the 8-bit value {`blank_end_hi[1:0]`, `blank_end_b5`, `blank_end_lo[4:0]`}. It is compared against all 8 bits of `hcount`, so the pulse lasts (end − start) mod 256 characters.
- R6: The end value is compared only while the window is open. A counter value that matches the end while the strobe is low is ignored. When the end value equals the start value in the low bits, the window therefore lasts the full 64 (or 256) characters.
- R7: With zero delay, `sync` rises when `hcount` becomes `sync_start`. It falls when the low 6 bits of `hcount` become {`sync_end_b5`, `sync_end_lo[4:0]`}, so the pulse lasts (end − start) mod 64 characters.
- R8: `sync_delay` = 0, 1, 2 or 3 delays both edges of `sync` by that many character-clock enables.
- R9: While `char_en` is low, `hcount`, `blank` and `sync` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_en | input | 1 | Character-clock enable |
| ext_mode | input | 1 | 0: 6-bit blank end, 1: 8-bit blank end |
| h_total | input | 8 | Last counter value of a line |
| blank_start | input | 8 | Counter value that opens blanking |
| blank_end_lo | input | 5 | Blank end bits 4..0 |
| blank_end_b5 | input | 1 | Blank end bit 5 |
| blank_end_hi | input | 2 | Blank end bits 7..6 (extended mode only) |
| sync_start | input | 8 | Counter value that opens sync |
| sync_end_lo | input | 5 | Sync end bits 4..0 |
| sync_end_b5 | input | 1 | Sync end bit 5 |
| sync_delay | input | 2 | Sync delay in character clocks |
| blank | output | 1 | Horizontal blanking, active-high |
| sync | output | 1 | Horizontal sync, active-high |
| hcount | output | 8 | Character counter |

## Verification
A wrong counter value appears on `hcount` at the very next enable. Because the windows key off that count, the same fault also moves both strobes within one line. A stale or stuck window flag shows up as a pulse that is too long or that never closes. This is most visible when the low-bit end value is first seen while the window is still closed, or when the standard and extended widths give different end points. A fault in the delay line shifts only `sync`, by a whole number of characters. Comparing every enable over full lines at each delay setting exposes it inside one line.

// File: rtl/crt_htiming_pkg.sv
`timescale 1ns/1ps
package crt_htiming_pkg;

    typedef enum logic {
        END_STD = 1'b0,
        END_EXT = 1'b1
    } end_mode_e;

    // Mask selecting the end-compare width: narrow bits in standard mode, all bits otherwise.
    function automatic logic [15:0] end_mask(input end_mode_e mode, input int narrow_w);
        logic [15:0] m;
        m = '1;
        if (mode == END_STD) begin
            m = 16'((17'd1 << narrow_w) - 17'd1);
        end
        return m;
    endfunction

endpackage

// File: rtl/crt_hcount.sv
`timescale 1ns/1ps
module crt_hcount #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             char_en,
    input  logic [CNT_W-1:0] total,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CNT_W-1:0] wrap_val;

    always_comb begin
        wrap_val = (st_q.cnt == total) ? '0 : st_q.cnt + 1'b1;
        st_d     = st_q;
        if (char_en) begin
            st_d.cnt = wrap_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt     = st_q.cnt;
    assign cnt_nxt = wrap_val;

endmodule

// File: rtl/crt_hwindow.sv
`timescale 1ns/1ps
module crt_hwindow #(
    parameter int CNT_W = 8,
    parameter int END_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             char_en,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] start_pos,
    input  logic [END_W-1:0] end_val,
    input  logic [END_W-1:0] end_msk,
    output logic             active
);

    typedef struct packed {
        logic act;
    } win_st_t;

    win_st_t st_d, st_q;
    logic    start_hit;
    logic    end_hit;

    always_comb begin
        start_hit = (cnt_nxt == start_pos);
        end_hit   = ((cnt_nxt[END_W-1:0] & end_msk) == (end_val & end_msk));
        st_d      = st_q;
        if (char_en) begin
            if (st_q.act) begin
                // end compare is only meaningful inside an open window
                if (end_hit) begin
                    st_d.act = 1'b0;
                end
            end else if (start_hit) begin
                st_d.act = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.act;

endmodule

// File: rtl/crt_hdelay.sv
`timescale 1ns/1ps
module crt_hdelay #(
    parameter int STAGES = 3,
    parameter int SEL_W  = $clog2(STAGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             char_en,
    input  logic             din,
    input  logic [SEL_W-1:0] sel,
    output logic             dout
);

    typedef struct packed {
        logic [STAGES-1:0] sr;
    } dly_st_t;

    dly_st_t           st_d, st_q;
    logic [STAGES:0]   taps;

    always_comb begin
        st_d = st_q;
        if (char_en) begin
            st_d.sr = STAGES'({st_q.sr, din});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // tap 0 is the undelayed input, tap k is k enables old
    assign taps = {st_q.sr, din};
    assign dout = (32'(sel) <= STAGES) ? taps[sel] : taps[STAGES];

endmodule

// File: rtl/crt_hblank_hsync.sv
`timescale 1ns/1ps
module crt_hblank_hsync
    import crt_htiming_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int STD_END_W  = 6,
    parameter int EXT_END_W  = 8,
    parameter int SYNC_END_W = 6,
    parameter int DLY_STAGES = 3,
    localparam int LO_W      = STD_END_W - 1,
    localparam int HI_W      = EXT_END_W - STD_END_W,
    localparam int SLO_W     = SYNC_END_W - 1,
    localparam int DLY_SEL_W = $clog2(DLY_STAGES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 char_en,
    input  logic                 ext_mode,
    input  logic [CNT_W-1:0]     h_total,
    input  logic [CNT_W-1:0]     blank_start,
    input  logic [LO_W-1:0]      blank_end_lo,
    input  logic                 blank_end_b5,
    input  logic [HI_W-1:0]      blank_end_hi,
    input  logic [CNT_W-1:0]     sync_start,
    input  logic [SLO_W-1:0]     sync_end_lo,
    input  logic                 sync_end_b5,
    input  logic [DLY_SEL_W-1:0] sync_delay,
    output logic                 blank,
    output logic                 sync,
    output logic [CNT_W-1:0]     hcount
);

    logic [CNT_W-1:0]      cnt_nxt;
    logic [EXT_END_W-1:0]  blank_end_val;
    logic [EXT_END_W-1:0]  blank_end_msk;
    logic [15:0]           msk_full;
    logic [SYNC_END_W-1:0] sync_end_val;
    logic                  sync_raw;

    always_comb begin
        blank_end_val = {blank_end_hi, blank_end_b5, blank_end_lo};
        msk_full      = end_mask(end_mode_e'(ext_mode), STD_END_W);
        blank_end_msk = msk_full[EXT_END_W-1:0];
        sync_end_val  = {sync_end_b5, sync_end_lo};
    end

    crt_hcount #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .char_en (char_en),
        .total   (h_total),
        .cnt     (hcount),
        .cnt_nxt (cnt_nxt)
    );

    crt_hwindow #(.CNT_W(CNT_W), .END_W(EXT_END_W)) u_blank (
        .clk       (clk),
        .rst_n     (rst_n),
        .char_en   (char_en),
        .cnt_nxt   (cnt_nxt),
        .start_pos (blank_start),
        .end_val   (blank_end_val),
        .end_msk   (blank_end_msk),
        .active    (blank)
    );

    crt_hwindow #(.CNT_W(CNT_W), .END_W(SYNC_END_W)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .char_en   (char_en),
        .cnt_nxt   (cnt_nxt),
        .start_pos (sync_start),
        .end_val   (sync_end_val),
        .end_msk   ({SYNC_END_W{1'b1}}),
        .active    (sync_raw)
    );

    generate
        if (DLY_STAGES > 0) begin : g_dly
            crt_hdelay #(.STAGES(DLY_STAGES), .SEL_W(DLY_SEL_W)) u_dly (
                .clk     (clk),
                .rst_n   (rst_n),
                .char_en (char_en),
                .din     (sync_raw),
                .sel     (sync_delay),
                .dout    (sync)
            );
        end else begin : g_nodly
            assign sync = sync_raw;
        end
    endgenerate

endmodule

// File: rtl/crt_hblank_hsync_chk.sv
`timescale 1ns/1ps
module crt_hblank_hsync_chk #(
    parameter int CNT_W     = 8,
    parameter int DLY_SEL_W = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 char_en,
    input logic [CNT_W-1:0]     h_total,
    input logic [CNT_W-1:0]     blank_start,
    input logic [CNT_W-1:0]     sync_start,
    input logic [DLY_SEL_W-1:0] sync_delay,
    input logic                 blank,
    input logic                 sync,
    input logic [CNT_W-1:0]     hcount
);

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (hcount == '0 && !blank && !sync));

    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (char_en && hcount != h_total) |=> hcount == CNT_W'($past(hcount) + 1'b1));

    a_r2_count_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (char_en && hcount == h_total) |=> hcount == '0);

    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !char_en |=> ($stable(hcount) && $stable(blank)
                      && ($stable(sync_delay) -> $stable(sync))));

    a_r3_blank_open: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blank) |-> hcount == $past(blank_start));

    a_r7_sync_open: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sync) && sync_delay == '0 && $past(sync_delay) == '0)
            |-> hcount == $past(sync_start));

endmodule

bind crt_hblank_hsync crt_hblank_hsync_chk #(
    .CNT_W     (CNT_W),
    .DLY_SEL_W (DLY_SEL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .char_en     (char_en),
    .h_total     (h_total),
    .blank_start (blank_start),
    .sync_start  (sync_start),
    .sync_delay  (sync_delay),
    .blank       (blank),
    .sync        (sync),
    .hcount      (hcount)
);

// File: tb/crt_hblank_hsync_tb.sv
`timescale 1ns/1ps
module crt_hblank_hsync_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       char_en = 1'b0;
    logic       ext_mode = 1'b0;
    logic [7:0] h_total = 8'd0;
    logic [7:0] blank_start = 8'd0;
    logic [4:0] blank_end_lo = 5'd0;
    logic       blank_end_b5 = 1'b0;
    logic [1:0] blank_end_hi = 2'd0;
    logic [7:0] sync_start = 8'd0;
    logic [4:0] sync_end_lo = 5'd0;
    logic       sync_end_b5 = 1'b0;
    logic [1:0] sync_delay = 2'd0;
    logic       blank;
    logic       sync;
    logic [7:0] hcount;

    int checks = 0;
    int fails  = 0;
    int exp_h  = 0;
    int hist [4];
    bit done = 1'b0;

    always #10 clk = ~clk;

    crt_hblank_hsync u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .char_en      (char_en),
        .ext_mode     (ext_mode),
        .h_total      (h_total),
        .blank_start  (blank_start),
        .blank_end_lo (blank_end_lo),
        .blank_end_b5 (blank_end_b5),
        .blank_end_hi (blank_end_hi),
        .sync_start   (sync_start),
        .sync_end_lo  (sync_end_lo),
        .sync_end_b5  (sync_end_b5),
        .sync_delay   (sync_delay),
        .blank        (blank),
        .sync         (sync),
        .hcount       (hcount)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (hcount model %0d)", req, act, exp, exp_h);
        end
    endtask

    // window length from the requirement: (end - start) mod 2^w, 0 means 2^w
    function automatic int win_len(input int s, input int e, input int w);
        int d;
        d = (e - s) & ((1 << w) - 1);
        return (d == 0) ? (1 << w) : d;
    endfunction

    function automatic bit in_win(input int h, input int s, input int len);
        return (h >= 0) && (h >= s) && (h < s + len);
    endfunction

    function automatic int blank_len();
        int e;
        if (ext_mode) begin
            e = {blank_end_hi, blank_end_b5, blank_end_lo};
            return win_len(blank_start, e, 8);
        end
        e = {blank_end_b5, blank_end_lo};
        return win_len(blank_start, e, 6);
    endfunction

    function automatic int sync_len();
        return win_len(sync_start, {sync_end_b5, sync_end_lo}, 6);
    endfunction

    task automatic apply_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        char_en = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #2;
        exp_h = 0;
        hist[0] = 0;
        for (int i = 1; i < 4; i++) hist[i] = -1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input bit en, input string rb, input string rs);
        @(negedge clk);
        char_en = en;
        @(posedge clk);
        #2;
        if (en) begin
            exp_h = (exp_h == int'(h_total)) ? 0 : exp_h + 1;
            for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = exp_h;
        end
        check(en ? "R2" : "R9", int'(hcount), exp_h);
        check(rb, int'(blank), int'(in_win(exp_h, blank_start, blank_len())));
        check(rs, int'(sync), int'(in_win(hist[sync_delay], sync_start, sync_len())));
    endtask

    task automatic run_lines(input int lines, input int gap, input string rb, input string rs);
        apply_reset();
        for (int n = 0; n < lines * (int'(h_total) + 1); n++) begin
            step(1'b1, rb, rs);
            for (int g = 0; g < gap; g++) step(1'b0, "R9", "R9");
        end
        @(negedge clk);
        char_en = 1'b0;
    endtask

    task automatic t_reset();
        h_total = 8'd30; blank_start = 8'd3; blank_end_lo = 5'd9; blank_end_b5 = 1'b0;
        sync_start = 8'd4; sync_end_lo = 5'd8; sync_end_b5 = 1'b0; sync_delay = 2'd2;
        run_lines(1, 0, "R3", "R8");
        // reset in the middle of a line: R1
        @(negedge clk);
        char_en = 1'b1;
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check("R1", int'(hcount), 0);
        check("R1", int'(blank), 0);
        check("R1", int'(sync), 0);
        @(negedge clk);
        char_en = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_count();
        h_total = 8'd20; blank_start = 8'd200; sync_start = 8'd200; sync_delay = 2'd0;
        run_lines(3, 2, "R2", "R2");
    endtask

    task automatic t_blank_std();
        // end 110 = {hi 01, b5 1, lo 01110}; standard view is 46
        h_total = 8'd200; blank_start = 8'd10; ext_mode = 1'b0;
        blank_end_lo = 5'd14; blank_end_b5 = 1'b1; blank_end_hi = 2'd1;
        sync_start = 8'd250;
        run_lines(2, 0, "R4", "R4");
    endtask

    task automatic t_blank_ext();
        ext_mode = 1'b1;
        run_lines(2, 0, "R5", "R5");
        ext_mode = 1'b0;
    endtask

    task automatic t_blank_full();
        // end low bits equal start: window spans 64 characters
        h_total = 8'd99; blank_start = 8'd5;
        blank_end_lo = 5'd5; blank_end_b5 = 1'b0; blank_end_hi = 2'd0;
        run_lines(2, 0, "R6", "R6");
        // end value 16 appears before start 70 and must be ignored
        blank_start = 8'd70; blank_end_lo = 5'd16;
        run_lines(2, 0, "R6", "R6");
    endtask

    task automatic t_sync();
        // start 100, width 8: end 108 mod 64 = 44 = {b5 1, lo 01100}
        h_total = 8'd150; blank_start = 8'd240;
        sync_start = 8'd100; sync_end_lo = 5'd12; sync_end_b5 = 1'b1;
        for (int d = 0; d < 4; d++) begin
            sync_delay = 2'(d);
            run_lines(2, (d == 3) ? 1 : 0, "R3", (d == 0) ? "R7" : "R8");
        end
    endtask

    initial begin
        t_reset();
        t_count();
        t_blank_std();
        t_blank_ext();
        t_blank_full();
        t_sync();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule